// File: doc/BRIEF.md
# Lights-Out Game Mode and Replay Controller

This block sits beside the 64-cell circular game register of a Lights-Out style puzzle engine. It watches the debounced key strobe and the coordinates of the held key. On each rising strobe while idle it opens a calculation cycle and classifies the key as one of four kinds: a board key, a new-game key, a manual-edit toggle or a replay key. It tells the surrounding feedback logic which data to push into the game register: fresh random bits, the replay store or the register's own recirculated bit. It also reports when the cycle may close.

The block holds a serial replay store that is as long as the game register. The store captures every freshly generated board and every board edited by hand. On all other cycles it rotates in step with the game register, so that a replay cycle can copy it back bit for bit. A solvability flag is computed from two parity checks over the visible 5x5 cells. During a new game the cycle is held open past its normal span until that flag is true. The random source is a plain input bit that is registered once per clock, so that the game register and the replay store both see one clean value.

Top module: `lo_mode_ctrl`

## Requirements
- R1: Key kinds are decoded from partial coordinates, in priority order: row equal to 7 means new game; otherwise column equal to 7 means manual toggle; otherwise column equal to 0 means replay; anything else is a board key. No other coordinate bits are examined.
- R2: A cycle starts (`busy` rises on the next clock) only on a rising `key_press` while `busy` is low. A rising `key_press` during a cycle has no effect on `busy`, `new_game` or `replay`, and it does not start a cycle afterwards.
- R3: `manual` is 0 after reset. It inverts at the start of each manual-toggle cycle and is constant at all other times.
- R4: The replay store shifts only on clocks with `busy` and `shift_en` high. In a new-game cycle, or in a cycle that begins with `manual` at 1 after any toggle, it shifts in `fb_bit`. Otherwise it rotates its oldest bit back in. `replay_bit` is the oldest bit. A replay cycle that feeds `replay_bit` into the game register for a full span restores the last captured board exactly.
- R5: `valid` is 1 exactly when both masked subsets of `board_cells` hold an even number of ones. Cell (r,c) is bit r*5+c. The first subset is the cells with c in {0,2,4} and r not equal to 2. The second subset is the cells with r in {0,2,4} and c not equal to 2.
- R6: `cycle_end` equals `busy` and `span_done` and (not `new_game` or `valid`). `busy` falls on the clock after `cycle_end`, so a new-game cycle never ends on an unsolvable board.
- R7: `rnd_q` equals `rand_raw` as sampled on the previous clock.
- R8: `new_game` and `replay` are high only while `busy`, never both at once, and they hold the kind latched at cycle start.
- R9: After reset `busy`, `new_game`, `replay`, `manual`, `rnd_q` and `replay_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_press | input | 1 | Debounced key strobe, high while a key is held |
| key_row | input | COORD_W | Row of the held key |
| key_col | input | COORD_W | Column of the held key |
| shift_en | input | 1 | Game register shifts on this clock |
| span_done | input | 1 | Normal cycle span (128 shifts) has elapsed |
| fb_bit | input | 1 | Bit entering the game register on this shift |
| board_cells | input | BOARD_W*BOARD_W | Visible cells, bit r*5+c |
| rand_raw | input | 1 | Raw biased random bit |
| busy | output | 1 | Calculation cycle in progress |
| new_game | output | 1 | Current cycle generates a new board |
| manual | output | 1 | Manual edit mode |
| replay | output | 1 | Current cycle restores the stored board |
| cycle_end | output | 1 | Cycle may close at this clock |
| rnd_q | output | 1 | Registered random bit |
| replay_bit | output | 1 | Serial output of the replay store |
| valid | output | 1 | Board passes both parity checks |

## Verification
The bench builds the block with its defaults: 3-bit coordinates, a 64-bit store and a 5x5 board. These values are small enough to sweep all 64 key coordinates through the decoder, every single lit cell and every pair of lit cells through the parity checks, and to model the complete game register in the bench. The bench then plays new-game cycles on a biased random stream. It checks that each cycle stays open while the board is unsolvable, then alters the board with board-key and manual cycles, and confirms that replay restores the captured board bit for bit.

// File: rtl/lo_mode_pkg.sv
package lo_mode_pkg;

    // Key classes produced by the partial-coordinate decoder.
    typedef enum logic [1:0] {
        KEY_PLAY   = 2'd0,
        KEY_NEW    = 2'd1,
        KEY_MANUAL = 2'd2,
        KEY_REPLAY = 2'd3
    } key_kind_e;

    // Default parity subsets for a 5x5 board, cell (r,c) at bit r*5+c.
    localparam logic [24:0] QUIET_A_DEF = 25'h15A82B5;
    localparam logic [24:0] QUIET_B_DEF = 25'h1B06C1B;

endpackage

// File: rtl/lo_key_classify.sv
module lo_key_classify
    import lo_mode_pkg::*;
#(
    parameter int unsigned COORD_W    = 3,
    parameter int unsigned NEW_ROW    = 7,
    parameter int unsigned MANUAL_COL = 7,
    parameter int unsigned REPLAY_COL = 0
) (
    input  logic [COORD_W-1:0] row,
    input  logic [COORD_W-1:0] col,
    output key_kind_e          kind
);
    localparam logic [COORD_W-1:0] NR = COORD_W'(NEW_ROW);
    localparam logic [COORD_W-1:0] MC = COORD_W'(MANUAL_COL);
    localparam logic [COORD_W-1:0] RC = COORD_W'(REPLAY_COL);

    // Only one coordinate is inspected per class; priority resolves overlaps.
    always_comb begin
        if (row == NR)      kind = KEY_NEW;
        else if (col == MC) kind = KEY_MANUAL;
        else if (col == RC) kind = KEY_REPLAY;
        else                kind = KEY_PLAY;
    end
endmodule

// File: rtl/lo_parity_tap.sv
module lo_parity_tap #(
    parameter int unsigned          CELLS = 25,
    parameter logic [CELLS-1:0]     MASK  = '1
) (
    input  logic [CELLS-1:0] cells,
    output logic             even
);
    assign even = ~^(cells & MASK);
endmodule

// File: rtl/lo_replay_ring.sv
module lo_replay_ring #(
    parameter int unsigned DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (step) begin
            ring_d.bits = {ring_q.bits[DEPTH-2:0], load ? din : ring_q.bits[DEPTH-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign dout = ring_q.bits[DEPTH-1];
endmodule

// File: rtl/lo_mode_ctrl.sv
module lo_mode_ctrl
    import lo_mode_pkg::*;
#(
    parameter int unsigned COORD_W    = 3,
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned BOARD_W    = 5,
    parameter int unsigned NEW_ROW    = 7,
    parameter int unsigned MANUAL_COL = 7,
    parameter int unsigned REPLAY_COL = 0,
    parameter logic [BOARD_W*BOARD_W-1:0] QUIET_A = QUIET_A_DEF,
    parameter logic [BOARD_W*BOARD_W-1:0] QUIET_B = QUIET_B_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         key_press,
    input  logic [COORD_W-1:0]           key_row,
    input  logic [COORD_W-1:0]           key_col,
    input  logic                         shift_en,
    input  logic                         span_done,
    input  logic                         fb_bit,
    input  logic [BOARD_W*BOARD_W-1:0]   board_cells,
    input  logic                         rand_raw,
    output logic                         busy,
    output logic                         new_game,
    output logic                         manual,
    output logic                         replay,
    output logic                         cycle_end,
    output logic                         rnd_q,
    output logic                         replay_bit,
    output logic                         valid
);
    localparam int unsigned CELLS   = BOARD_W * BOARD_W;
    localparam int unsigned N_QUIET = 2;
    localparam logic [CELLS-1:0] QMASK [N_QUIET] = '{QUIET_A, QUIET_B};

    typedef struct packed {
        logic key_prev;
        logic busy;
        logic ng;
        logic rp;
        logic ld;
        logic manual;
        logic rnd;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    key_kind_e kind;
    logic [N_QUIET-1:0] even_vec;
    logic      start;
    logic      man_after;

    lo_key_classify #(
        .COORD_W   (COORD_W),
        .NEW_ROW   (NEW_ROW),
        .MANUAL_COL(MANUAL_COL),
        .REPLAY_COL(REPLAY_COL)
    ) u_classify (
        .row (key_row),
        .col (key_col),
        .kind(kind)
    );

    for (genvar gi = 0; gi < N_QUIET; gi++) begin : g_quiet
        lo_parity_tap #(
            .CELLS(CELLS),
            .MASK (QMASK[gi])
        ) u_tap (
            .cells(board_cells),
            .even (even_vec[gi])
        );
    end

    assign valid     = &even_vec;
    assign cycle_end = ctl_q.busy & span_done & (~ctl_q.ng | valid);

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.key_prev = key_press;
        ctl_d.rnd      = rand_raw;
        start          = key_press & ~ctl_q.key_prev & ~ctl_q.busy;
        man_after      = ctl_q.manual ^ (kind == KEY_MANUAL);

        if (cycle_end) begin
            ctl_d.busy = 1'b0;
            ctl_d.ng   = 1'b0;
            ctl_d.rp   = 1'b0;
            ctl_d.ld   = 1'b0;
        end

        if (start) begin
            ctl_d.busy   = 1'b1;
            ctl_d.ng     = (kind == KEY_NEW);
            ctl_d.rp     = (kind == KEY_REPLAY);
            ctl_d.manual = man_after;
            ctl_d.ld     = (kind == KEY_NEW) | man_after;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    lo_replay_ring #(
        .DEPTH(DEPTH)
    ) u_ring (
        .clk  (clk),
        .rst_n(rst_n),
        .step (ctl_q.busy & shift_en),
        .load (ctl_q.ld),
        .din  (fb_bit),
        .dout (replay_bit)
    );

    assign busy     = ctl_q.busy;
    assign new_game = ctl_q.ng;
    assign replay   = ctl_q.rp;
    assign manual   = ctl_q.manual;
    assign rnd_q    = ctl_q.rnd;
endmodule

// File: rtl/lo_mode_ctrl_chk.sv
module lo_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic key_press,
    input logic shift_en,
    input logic rand_raw,
    input logic busy,
    input logic new_game,
    input logic manual,
    input logic replay,
    input logic cycle_end,
    input logic rnd_q,
    input logic replay_bit,
    input logic valid
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r2_cycle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cycle_end |=> busy);

    a_r2_start_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(key_press));

    a_r3_manual_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(manual) |-> $rose(busy));

    a_r4_ring_still_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && shift_en) |=> $stable(replay_bit));

    a_r6_close_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !busy);

    a_r6_newgame_waits_valid: assert property (@(posedge clk) disable iff (!rst_n)
        new_game && !valid |-> !cycle_end);

    a_r7_random_registered: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> rnd_q == $past(rand_raw));

    a_r8_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({new_game, replay}));

    a_r8_kinds_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (new_game || replay) |-> busy);
endmodule

bind lo_mode_ctrl lo_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_press (key_press),
    .shift_en  (shift_en),
    .rand_raw  (rand_raw),
    .busy      (busy),
    .new_game  (new_game),
    .manual    (manual),
    .replay    (replay),
    .cycle_end (cycle_end),
    .rnd_q     (rnd_q),
    .replay_bit(replay_bit),
    .valid     (valid)
);

// File: tb/tb_lo_mode_ctrl.sv
module tb_lo_mode_ctrl;
    localparam int CW = 3;
    localparam int CELLS = 25;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, key_press, shift_en, span_done, fb_bit, rand_raw;
    logic [CW-1:0] key_row, key_col;
    logic [CELLS-1:0] board_cells;
    logic busy, new_game, manual, replay, cycle_end, rnd_q, replay_bit, valid;

    logic [63:0] game_m;
    logic [15:0] lfsr;
    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit man_exp = 1'b0;

    lo_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .key_press(key_press), .key_row(key_row),
        .key_col(key_col), .shift_en(shift_en), .span_done(span_done),
        .fb_bit(fb_bit), .board_cells(board_cells), .rand_raw(rand_raw),
        .busy(busy), .new_game(new_game), .manual(manual), .replay(replay),
        .cycle_end(cycle_end), .rnd_q(rnd_q), .replay_bit(replay_bit), .valid(valid)
    );

    function automatic logic [CELLS-1:0] visible(input logic [63:0] g);
        logic [CELLS-1:0] v;
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++)
                v[r*5+c] = g[(r+1)*8 + c + 1];
        return v;
    endfunction

    function automatic logic exp_valid(input logic [CELLS-1:0] b);
        logic pa, pb;
        pa = 1'b0; pb = 1'b0;
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++) begin
                if ((c % 2 == 0) && (r != 2)) pa = pa ^ b[r*5+c];
                if ((r % 2 == 0) && (c != 2)) pb = pb ^ b[r*5+c];
            end
        return !pa && !pb;
    endfunction

    assign board_cells = visible(game_m);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rand_raw = lfsr[0] | lfsr[3];
    endtask

    // One game-register shift; the bench plays the feedback logic.
    task automatic shift_step(input bit flip);
        logic f;
        next_rand();
        if (new_game)    f = rnd_q;
        else if (replay) f = replay_bit;
        else             f = game_m[63] ^ flip;
        shift_en = 1'b1;
        fb_bit = f;
        @(negedge clk);
        game_m = {game_m[62:0], f};
        shift_en = 1'b0;
    endtask

    task automatic run_cycle(input int row, input int col, input int flip_at, output int shifts);
        @(negedge clk);
        key_row = CW'(row); key_col = CW'(col); key_press = 1'b1;
        @(negedge clk);
        key_press = 1'b0;
        shifts = 0;
        for (int i = 0; i < 128; i++) begin
            shift_step(flip_at == i);
            shifts++;
        end
        span_done = 1'b1;
        #1;
        while (!cycle_end && shifts < 4000) begin
            check("R6 open cycle only on unsolvable board", {63'd0, exp_valid(visible(game_m))}, 64'd0);
            span_done = 1'b0;
            shift_step(1'b0);
            shifts++;
            span_done = 1'b1;
            #1;
        end
        @(negedge clk);
        span_done = 1'b0;
        check("R6 busy falls after cycle_end", {63'd0, busy}, 64'd0);
    endtask

    // Press a key and close the cycle at once, with no shifts.
    task automatic tap(input int row, input int col);
        bit exp_ng, exp_rp, exp_mt;
        exp_ng = (row == 7);
        exp_mt = !exp_ng && (col == 7);
        exp_rp = !exp_ng && !exp_mt && (col == 0);
        if (exp_mt) man_exp = !man_exp;
        @(negedge clk);
        key_row = CW'(row); key_col = CW'(col); key_press = 1'b1;
        @(negedge clk);
        key_press = 1'b0;
        check("R2 busy after press", {63'd0, busy}, 64'd1);
        check("R1 new_game decode", {63'd0, new_game}, {63'd0, exp_ng});
        check("R1 replay decode", {63'd0, replay}, {63'd0, exp_rp});
        check("R3 manual toggle", {63'd0, manual}, {63'd0, man_exp});
        span_done = 1'b1;
        @(negedge clk);
        span_done = 1'b0;
        check("R8 flags clear after cycle", {62'd0, new_game, replay}, 64'd0);
        check("R6 busy falls", {63'd0, busy}, 64'd0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [63:0] snap, snap2;
        int sh;
        rst_n = 1'b0; key_press = 1'b0; key_row = '0; key_col = '0;
        shift_en = 1'b0; span_done = 1'b0; fb_bit = 1'b0; rand_raw = 1'b0;
        lfsr = 16'hACE1; game_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 reset outputs",
              {58'd0, busy, new_game, replay, manual, rnd_q, replay_bit}, 64'd0);
        check("R5 empty board valid", {63'd0, valid}, 64'd1);

        // R7 random register
        for (int i = 0; i < 8; i++) begin
            logic x;
            next_rand();
            x = rand_raw;
            @(negedge clk);
            check("R7 rnd_q follows rand_raw", {63'd0, rnd_q}, {63'd0, x});
        end

        // R1 / R3 / R8 sweep of every coordinate
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                tap(r, c);
        if (man_exp) tap(3, 7);

        // R2 press during a cycle is ignored
        @(negedge clk);
        key_row = 3'd2; key_col = 3'd3; key_press = 1'b1;
        @(negedge clk);
        key_press = 1'b0;
        @(negedge clk);
        key_row = 3'd7; key_col = 3'd4; key_press = 1'b1;
        @(negedge clk);
        check("R2 press while busy ignored", {62'd0, busy, new_game}, 64'd2);
        key_press = 1'b0;
        span_done = 1'b1;
        @(negedge clk);
        span_done = 1'b0;
        @(negedge clk);
        check("R2 no late cycle start", {62'd0, busy, new_game}, 64'd0);

        // R5 parity sweeps over single cells and cell pairs
        for (int i = 0; i < CELLS; i++) begin
            game_m = '0;
            game_m[((i/5)+1)*8 + (i%5) + 1] = 1'b1;
            #1;
            check("R5 single cell", {63'd0, valid}, {63'd0, exp_valid(visible(game_m))});
            for (int j = i + 1; j < CELLS; j++) begin
                game_m[((j/5)+1)*8 + (j%5) + 1] = 1'b1;
                #1;
                check("R5 cell pair", {63'd0, valid}, {63'd0, exp_valid(visible(game_m))});
                game_m[((j/5)+1)*8 + (j%5) + 1] = 1'b0;
            end
        end
        game_m = '1;
        #1;
        check("R5 full board", {63'd0, valid}, {63'd0, exp_valid(visible(game_m))});
        game_m = '0;

        // New game, alter, replay
        for (int g = 0; g < 3; g++) begin
            run_cycle(7, 5, -1, sh);
            check("R6 new game board solvable", {63'd0, exp_valid(visible(game_m))}, 64'd1);
            check("R5 valid after new game", {63'd0, valid}, 64'd1);
            check("R6 new game ran full span", {63'd0, sh >= 128}, 64'd1);
            snap = game_m;
            run_cycle(2, 3, 20 + g, sh);
            check("R4 board altered by play", {63'd0, game_m != snap}, 64'd1);
            run_cycle(6, 0, -1, sh);
            check("R4 replay restores new board", game_m, snap);
        end

        // Manual edit captured, then replayed
        run_cycle(4, 7, -1, sh);
        check("R3 manual on", {63'd0, manual}, 64'd1);
        run_cycle(2, 2, 5, sh);
        snap2 = game_m;
        check("R4 manual edit changed board", {63'd0, snap2 != snap}, 64'd1);
        run_cycle(3, 7, -1, sh);
        check("R3 manual off", {63'd0, manual}, 64'd0);
        run_cycle(1, 1, 9, sh);
        check("R4 board altered after manual", {63'd0, game_m != snap2}, 64'd1);
        run_cycle(5, 0, -1, sh);
        check("R4 replay restores manual board", game_m, snap2);

        finish_run();
    end
endmodule